// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block is the hazard-control unit of a five-stage in-order integer pipeline. Each cycle it looks at the source register numbers of the instruction in execute, along with the destinations of the instructions further down the pipe in the memory and write-back stages. From these it picks where each ALU operand comes from. An operand can come from the register file, the memory-stage ALU result, the write-back result, or, for the second operand only, the immediate. The checks run in a fixed order: the immediate first, then the newest in-flight result, then the older one, then the register file.

Loaded data only arrives at the end of the memory stage, so forwarding alone cannot serve an instruction that consumes a load result straight away. The unit raises a stall in that case. The stall holds the PC and the decode register and sends a bubble (an instruction with its valid bit cleared) into execute. The stall can come from two sources:
- a comparator that matches the execute sources against a load in the memory stage;
- a reservation bit per register, which a load sets while it is in decode and clears once it reaches the memory stage.

A parameter chooses which of the two sources drive the stall, or whether both do.

Top module: `hzd_fwd_unit`

## Requirements
- R1: When `ex_use_imm` is 1, `opb_sel` is 3 (immediate), whatever the register matches are.
- R2: When no immediate is used and `ex_rs2` equals `mem_rd` with `mem_we` = 1, `opb_sel` is 1 (memory-stage result), even if write-back also matches.
- R3: Otherwise, if `ex_rs2` equals `wb_rd` with `wb_we` = 1, `opb_sel` is 2 (write-back result); with no match at all it is 0 (register file).
- R4: `opa_sel` follows the same order for `ex_rs1` (1 for memory stage, then 2 for write-back, else 0) and is never changed by `ex_use_imm`.
- R5: A destination of register 0, or a stage with its write enable at 0, never causes forwarding; the select stays 0 (or 3 for an immediate on operand B).
- R6: With the default stall mode, `stall` is 1 when `mem_load` = 1, `mem_we` = 1, `mem_rd` is not 0 and `mem_rd` equals `ex_rs1` or `ex_rs2`. A matching instruction in memory that is not a load does not stall.
- R7: A load in decode (`id_load` = 1, `id_we` = 1, `id_rd` not 0) reserves `id_rd` at the next clock edge. From then on, a decode instruction whose `id_rs1` or `id_rs2` names a reserved register gets `stall` = 1.
- R8: A reservation is released in the same cycle that a load to that register is in the memory stage, so a dependent instruction sees a single stall cycle. The bit stays clear after that edge. If one load sets a register in decode while another clears it in memory in the same cycle, the set wins.
- R9: Reset clears every reservation, and register 0 can never be reserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the reservation bits |
| rst_n | input | 1 | Active-low asynchronous reset |
| ex_rs1 | input | 5 | First source register of the execute instruction |
| ex_rs2 | input | 5 | Second source register of the execute instruction |
| ex_use_imm | input | 1 | Execute instruction takes operand B from its immediate |
| mem_rd | input | 5 | Destination register in memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Destination register in write-back stage |
| wb_we | input | 1 | Write-back instruction writes a register |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_rd | input | 5 | Destination register of the decode instruction |
| id_we | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| opa_sel | output | 2 | Operand A source: 0 register, 1 memory, 2 write-back |
| opb_sel | output | 2 | Operand B source: 0 register, 1 memory, 2 write-back, 3 immediate |
| stall | output | 1 | Hold PC and decode, insert a bubble into execute |

## Verification
The hardest state to reach is the reservation register in its corner cases. The first is a release that happens in the very cycle a dependent instruction is waiting in decode. The second is a new load setting a register in the same edge that an older load to that register clears it. Neither can be seen directly at the ports. The bench builds each one as a timed sequence:
- it drives a decode load;
- it clocks the edge;
- it places the matching load in the memory stage while a consumer sits in decode;
- it then looks at `stall` before and after the following edge.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      SEL_RF  = 2'd0,
      SEL_MEM = 2'd1,
      SEL_WB  = 2'd2,
      SEL_IMM = 2'd3
   } opsel_e;

   localparam int STALL_CMP  = 0;
   localparam int STALL_RSV  = 1;
   localparam int STALL_BOTH = 2;
endpackage

// File: rtl/hzd_opsel.sv
module hzd_opsel
   import hzd_pkg::*;
#(
   parameter int AW      = 5,
   parameter bit HAS_IMM = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] src,
   input  logic          use_imm,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_we,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_we,
   output opsel_e        sel
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic imm_hit, mem_hit, wb_hit;

   assign imm_hit = HAS_IMM && use_imm;
   assign mem_hit = mem_we && (mem_rd != ZERO_REG) && (mem_rd == src);
   assign wb_hit  = wb_we  && (wb_rd  != ZERO_REG) && (wb_rd  == src);

   always_comb begin
      if (imm_hit)      sel = SEL_IMM;
      else if (mem_hit) sel = SEL_MEM;
      else if (wb_hit)  sel = SEL_WB;
      else              sel = SEL_RF;
   end

   assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (src == ZERO_REG) |-> (sel == SEL_RF || sel == SEL_IMM));

   assert_no_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we && !wb_we) |-> (sel == SEL_RF || sel == SEL_IMM));

   generate
      if (HAS_IMM) begin : g_imm_chk
         assert_imm_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
            use_imm |-> (sel == SEL_IMM));
      end else begin : g_noimm_chk
         assert_no_imm_on_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
            sel != SEL_IMM);
      end
   endgenerate
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rs1,
   input  logic [AW-1:0] rs2,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_we,
   input  logic          mem_load,
   output logic          hit
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic pending;

   assign pending = mem_load && mem_we && (mem_rd != ZERO_REG);
   assign hit     = pending && ((rs1 == mem_rd) || (rs2 == mem_rd));

   assert_only_loads_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_load |-> !hit);
endmodule

// File: rtl/hzd_rsv_track.sv
module hzd_rsv_track #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic [AW-1:0] id_rd,
   input  logic          id_we,
   input  logic          id_load,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_we,
   input  logic          mem_load,
   output logic          hit
);
   localparam int NREGS = 1 << AW;
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic [NREGS-1:0] rsv_q, set_v, clr_v, live_v;

   always_comb begin
      set_v = '0;
      clr_v = '0;
      if (id_load && id_we && (id_rd != ZERO_REG))
         set_v[id_rd] = 1'b1;
      if (mem_load && mem_we && (mem_rd != ZERO_REG))
         clr_v[mem_rd] = 1'b1;
   end

   assign live_v = rsv_q & ~clr_v;
   assign hit    = live_v[id_rs1] | live_v[id_rs2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsv_q <= '0;
      else        rsv_q <= live_v | set_v;
   end

   assert_zero_unreserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsv_q[0]);

   assert_set_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_v) |=> (($past(set_v) & ~rsv_q) == '0));

   assert_clear_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_v) |=> (($past(clr_v & ~set_v) & rsv_q) == '0));
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
   import hzd_pkg::*;
#(
   parameter int AW         = 5,
   parameter int STALL_MODE = STALL_BOTH
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ex_rs1,
   input  logic [AW-1:0] ex_rs2,
   input  logic          ex_use_imm,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_we,
   input  logic          mem_load,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_we,
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic [AW-1:0] id_rd,
   input  logic          id_we,
   input  logic          id_load,
   output logic [1:0]    opa_sel,
   output logic [1:0]    opb_sel,
   output logic          stall
);
   generate
      if (AW < 2 || AW > 8) begin : g_bad_aw
         $error("hzd_fwd_unit: AW must be within 2..8");
      end
      if (STALL_MODE < STALL_CMP || STALL_MODE > STALL_BOTH) begin : g_bad_mode
         $error("hzd_fwd_unit: STALL_MODE must be 0, 1 or 2");
      end
   endgenerate

   opsel_e sel_a, sel_b;
   logic   cmp_hit, rsv_hit;

   hzd_opsel #(.AW(AW), .HAS_IMM(1'b0)) u_sel_a (
      .clk(clk), .rst_n(rst_n), .src(ex_rs1), .use_imm(ex_use_imm),
      .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
      .sel(sel_a));

   hzd_opsel #(.AW(AW), .HAS_IMM(1'b1)) u_sel_b (
      .clk(clk), .rst_n(rst_n), .src(ex_rs2), .use_imm(ex_use_imm),
      .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
      .sel(sel_b));

   hzd_loaduse #(.AW(AW)) u_cmp (
      .clk(clk), .rst_n(rst_n), .rs1(ex_rs1), .rs2(ex_rs2),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .hit(cmp_hit));

   hzd_rsv_track #(.AW(AW)) u_rsv (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_rd(id_rd), .id_we(id_we), .id_load(id_load),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .hit(rsv_hit));

   generate
      if (STALL_MODE == STALL_CMP) begin : g_stall_cmp
         assign stall = cmp_hit;
      end else if (STALL_MODE == STALL_RSV) begin : g_stall_rsv
         assign stall = rsv_hit;
      end else begin : g_stall_both
         assign stall = cmp_hit | rsv_hit;
      end
   endgenerate

   assign opa_sel = sel_a;
   assign opb_sel = sel_b;

   assert_stall_has_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> (mem_load || $past(id_load) || rsv_hit));
endmodule

// File: tb/sim_hzd_fwd_unit.sv
module sim_hzd_fwd_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] ex_rs1, ex_rs2, mem_rd, wb_rd, id_rs1, id_rs2, id_rd;
   logic       ex_use_imm, mem_we, mem_load, wb_we, id_we, id_load;
   logic [1:0] opa_sel, opb_sel;
   logic       stall;
   int         n_tests = 0;
   int         n_fail  = 0;

   always #10 clk = ~clk;

   hzd_fwd_unit u0 (
      .clk(clk), .rst_n(rst_n), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
      .ex_use_imm(ex_use_imm), .mem_rd(mem_rd), .mem_we(mem_we),
      .mem_load(mem_load), .wb_rd(wb_rd), .wb_we(wb_we),
      .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rd(id_rd), .id_we(id_we),
      .id_load(id_load), .opa_sel(opa_sel), .opb_sel(opb_sel), .stall(stall));

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      ex_rs1 = 0; ex_rs2 = 0; ex_use_imm = 0;
      mem_rd = 0; mem_we = 0; mem_load = 0;
      wb_rd = 0; wb_we = 0;
      id_rs1 = 0; id_rs2 = 0; id_rd = 0; id_we = 0; id_load = 0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      for (int r = 0; r < 32; r++) begin
         id_rs1 = 5'(r); id_rs2 = 5'(31 - r);
         #1;
         chk("R9 reset no reservation", int'(stall), 0);
      end
      chk("R3 reset select A", int'(opa_sel), 0);
      chk("R3 reset select B", int'(opb_sel), 0);
      idle();
   endtask

   task automatic t_opb_order();
      settle(); idle();
      ex_rs2 = 4; mem_rd = 4; mem_we = 1; wb_rd = 4; wb_we = 1; ex_use_imm = 1;
      #5 chk("R1 immediate beats matches", int'(opb_sel), 3);
      ex_use_imm = 0;
      #5 chk("R2 memory beats write-back", int'(opb_sel), 1);
      mem_rd = 6;
      #5 chk("R3 write-back match", int'(opb_sel), 2);
      wb_rd = 7;
      #5 chk("R3 no match uses register", int'(opb_sel), 0);
      ex_rs2 = 6;
      #5 chk("R2 memory only match", int'(opb_sel), 1);
      idle();
   endtask

   task automatic t_opa_order();
      settle(); idle();
      ex_rs1 = 9; ex_use_imm = 1; mem_rd = 9; mem_we = 1; wb_rd = 9; wb_we = 1;
      #5 chk("R4 A memory first, imm ignored", int'(opa_sel), 1);
      mem_rd = 3;
      #5 chk("R4 A write-back", int'(opa_sel), 2);
      wb_rd = 2;
      #5 chk("R4 A register", int'(opa_sel), 0);
      idle();
   endtask

   task automatic t_zero_and_we();
      settle(); idle();
      ex_rs1 = 0; ex_rs2 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
      #5 chk("R5 reg0 A", int'(opa_sel), 0);
      chk("R5 reg0 B", int'(opb_sel), 0);
      ex_rs1 = 11; ex_rs2 = 11; mem_rd = 11; mem_we = 0; wb_rd = 11; wb_we = 0;
      #5 chk("R5 we low A", int'(opa_sel), 0);
      chk("R5 we low B", int'(opb_sel), 0);
      ex_use_imm = 1;
      #5 chk("R5 we low B imm", int'(opb_sel), 3);
      idle();
   endtask

   task automatic t_cmp_stall();
      settle(); idle();
      ex_rs1 = 8; ex_rs2 = 1; mem_rd = 8; mem_we = 1; mem_load = 1;
      #5 chk("R6 load match rs1", int'(stall), 1);
      ex_rs1 = 2; ex_rs2 = 8;
      #5 chk("R6 load match rs2", int'(stall), 1);
      mem_load = 0;
      #5 chk("R6 non-load no stall", int'(stall), 0);
      chk("R6 non-load forwards", int'(opb_sel), 1);
      mem_load = 1; ex_rs2 = 3;
      #5 chk("R6 load no match", int'(stall), 0);
      mem_rd = 0; ex_rs1 = 0; ex_rs2 = 0;
      #5 chk("R6 load to reg0", int'(stall), 0);
      idle();
   endtask

   task automatic t_rsv_track();
      settle(); idle();
      id_load = 1; id_we = 1; id_rd = 7;
      #5 chk("R7 not reserved before edge", int'(stall), 0);
      settle();
      id_load = 0; id_we = 1; id_rd = 9; id_rs1 = 7; id_rs2 = 1;
      #5 chk("R7 reserved rs1 stalls", int'(stall), 1);
      id_rs1 = 1; id_rs2 = 7;
      #5 chk("R7 reserved rs2 stalls", int'(stall), 1);
      id_rs2 = 3;
      #5 chk("R7 other reg free", int'(stall), 0);
      id_rs1 = 7;
      mem_load = 1; mem_we = 1; mem_rd = 7; ex_rs1 = 1; ex_rs2 = 2;
      #5 chk("R8 release in memory cycle", int'(stall), 0);
      settle();
      mem_load = 0; mem_we = 0; mem_rd = 0;
      #5 chk("R8 bit clear after edge", int'(stall), 0);
      idle();
   endtask

   task automatic t_rsv_setclear();
      settle(); idle();
      id_load = 1; id_we = 1; id_rd = 12;
      settle();
      mem_load = 1; mem_we = 1; mem_rd = 12;
      settle();
      idle(); id_rs1 = 12;
      #5 chk("R8 set wins over clear", int'(stall), 1);
      mem_load = 1; mem_we = 1; mem_rd = 12;
      settle();
      idle(); id_rs1 = 12;
      #5 chk("R8 later clear releases", int'(stall), 0);
      id_load = 1; id_we = 1; id_rd = 0;
      settle();
      idle(); id_rs1 = 0;
      #5 chk("R9 reg0 never reserved", int'(stall), 0);
      idle();
   endtask

   initial begin
      #(20 * 200000);
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_opb_order();
      t_opa_order();
      t_zero_and_we();
      t_cmp_stall();
      t_rsv_track();
      t_rsv_setclear();
      settle();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule